// File: doc/BRIEF.md
# Auto-Baud UART Boot Handshake

This block is the serial front end that runs first after reset and works out the host's bit rate by itself. While the host keeps sending zero bytes, the block times the low phase of one of them (the start bit and eight zero data bits, nine bit times in all) in system clocks. It rounds that count divided by nine to get the bit period, and places it on a 16-bit output for downstream use.

Once the period is known, the block pulses `lock` and sends one zero byte back at the learned rate to mark the end of adjustment. It then listens for a single 0x55 byte from the host, framed as 8 data bits, one stop bit and no parity. A correct byte raises `done`. Anything else raises `error`, which stays set until reset. Reset starts the whole sequence again.

A timing attempt is dropped when its low pulse is too short or when the low counter saturates. Timing starts only on a falling edge that comes after the line has been idle long enough, so a measurement cannot begin in the middle of a byte. The counter width covers nine bit times at 4800 bps with an 18 MHz clock. Host rates of 4800, 9600 and 19200 bps are the intended use.

Top module: `autobaud_boot`

## Requirements
- R1: While reset is applied and right after it is released, `txd` is 1, `lock`, `done` and `error` are 0, and `bit_period` is 0.
- R2: The rx line passes through two synchronizing flops. The low length L is the number of clocks the line stays low. `bit_period` becomes floor((L+4)/9), which is L/9 rounded to the nearest integer, and it is nonzero whenever `lock` is 1.
- R3: A low pulse with L < MIN_LOW is discarded, and so is one with L >= 2^CNT_W-1 (the counter saturates). After a discard the block keeps waiting for the next low pulse and does not pulse `lock`.
- R4: A falling edge starts timing only if the line was high for at least MIN_IDLE clocks just before it. An earlier falling edge is ignored, and so is the rest of that low pulse.
- R5: `lock` is high for exactly one clock, at most once per reset. `bit_period` does not change from that clock until the next reset.
- R6: The clock after `lock`, `txd` starts one 8N1 frame carrying 0x00 at `bit_period` clocks per bit. `txd` is low for exactly 9*`bit_period` clocks, then high for the stop bit.
- R7: After that frame ends, the receiver samples each bit at half a bit period after the start edge, LSB first. If it receives 0x55 with a high stop bit, `done` rises and stays 1 until reset.
- R8: If the first byte received after the frame is not 0x55, or its stop bit samples low, `error` rises and stays 1 until reset. `done` stays 0.
- R9: A reset applied after success or error restarts the sequence, and a new measurement is taken at a possibly different rate.
- R10: `done` and `error` are never both 1. `txd` stays high from reset until `lock`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rxd | input | 1 | Serial data from the host (asynchronous) |
| txd | output | 1 | Serial data to the host, idle high |
| bit_period | output | 16 | Learned bit period in clocks |
| lock | output | 1 | One-clock pulse when the rate has been learned |
| done | output | 1 | Set after a correct 0x55 confirmation |
| error | output | 1 | Set after a wrong or badly framed confirmation |

## Verification
The assertions assume three things about the host. Each measured low phase is a single clean pulse with no glitches inside it. The host sends its confirmation byte at the learned period. The host does not start that byte before the block's stop bit has ended. The stimulus changes `rxd` only on falling clock edges and holds each level for an exact whole number of clocks, so the low length L is known exactly. It sends the confirmation frame at exactly the expected period, and only after it has seen the complete zero frame and the stop bit on `txd`. The sweep covers every low length from MIN_LOW up through several nine-clock steps, including lengths that are not multiples of nine, so both rounding directions are exercised.

// File: rtl/abb_pkg.sv
package abb_pkg;

    localparam int LOW_BITS   = 9;
    localparam int DATA_BITS  = 8;
    localparam int FRAME_BITS = 10;
    localparam int ROUND_ADD  = LOW_BITS / 2;

    localparam logic [7:0] ADJ_END_BYTE = 8'h00;
    localparam logic [7:0] CONFIRM_BYTE = 8'h55;

    typedef enum logic [2:0] {
        HS_MEASURE,
        HS_DIVIDE,
        HS_SEND,
        HS_CONFIRM,
        HS_DONE,
        HS_FAIL
    } hs_state_e;

    typedef enum logic [2:0] {
        RX_ARM,
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_STOP
    } rx_state_e;

endpackage

// File: rtl/abb_sync.sv
module abb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d = {pipe_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '1;
        else        pipe_q <= pipe_d;
    end

    assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/abb_low_timer.sv
module abb_low_timer #(
    parameter int CNT_W    = 18,
    parameter int MIN_LOW  = 36,
    parameter int MIN_IDLE = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             line,
    output logic             meas_valid,
    output logic             meas_ok,
    output logic [CNT_W-1:0] meas_cnt
);
    localparam int               IDLE_W  = $clog2(MIN_IDLE + 1);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic              timing;
        logic [CNT_W-1:0]  cnt;
        logic [IDLE_W-1:0] idle;
        logic              valid;
        logic              ok;
        logic [CNT_W-1:0]  res;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d       = tmr_q;
        tmr_d.valid = 1'b0;
        if (line) begin
            if (tmr_q.idle < IDLE_W'(MIN_IDLE)) tmr_d.idle = tmr_q.idle + 1'b1;
            if (tmr_q.timing) begin
                tmr_d.timing = 1'b0;
                tmr_d.valid  = 1'b1;
                tmr_d.res    = tmr_q.cnt;
                tmr_d.ok     = (tmr_q.cnt >= CNT_W'(MIN_LOW)) && (tmr_q.cnt != CNT_MAX);
            end
        end else begin
            tmr_d.idle = '0;
            if (tmr_q.timing) begin
                if (tmr_q.cnt != CNT_MAX) tmr_d.cnt = tmr_q.cnt + 1'b1;
            end else if (tmr_q.idle >= IDLE_W'(MIN_IDLE)) begin
                tmr_d.timing = 1'b1;
                tmr_d.cnt    = CNT_W'(1);
            end
        end
        if (!en) begin
            tmr_d.timing = 1'b0;
            tmr_d.valid  = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end

    assign meas_valid = tmr_q.valid;
    assign meas_ok    = tmr_q.ok;
    assign meas_cnt   = tmr_q.res;
endmodule

// File: rtl/abb_div_const.sv
module abb_div_const #(
    parameter int IN_W    = 19,
    parameter int DIVISOR = 9
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [IN_W-1:0] dividend,
    output logic            done,
    output logic [IN_W-1:0] quot
);
    localparam int REM_W = $clog2(DIVISOR);
    localparam int IDX_W = $clog2(IN_W + 1);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic [IDX_W-1:0] idx;
        logic [REM_W-1:0] rem;
        logic [IN_W-1:0]  num;
        logic [IN_W-1:0]  q;
    } div_t;

    div_t div_d, div_q;
    logic [REM_W:0] trial;

    always_comb begin
        div_d      = div_q;
        div_d.done = 1'b0;
        trial      = {div_q.rem, div_q.num[IN_W-1]};
        if (!div_q.busy) begin
            if (start) begin
                div_d.busy = 1'b1;
                div_d.num  = dividend;
                div_d.q    = '0;
                div_d.rem  = '0;
                div_d.idx  = '0;
            end
        end else begin
            if (trial >= (REM_W+1)'(DIVISOR)) begin
                div_d.rem = REM_W'(trial - (REM_W+1)'(DIVISOR));
                div_d.q   = {div_q.q[IN_W-2:0], 1'b1};
            end else begin
                div_d.rem = trial[REM_W-1:0];
                div_d.q   = {div_q.q[IN_W-2:0], 1'b0};
            end
            div_d.num = {div_q.num[IN_W-2:0], 1'b0};
            if (div_q.idx == IDX_W'(IN_W - 1)) begin
                div_d.busy = 1'b0;
                div_d.done = 1'b1;
            end else begin
                div_d.idx = div_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign done = div_q.done;
    assign quot = div_q.q;
endmodule

// File: rtl/abb_uart_tx.sv
module abb_uart_tx #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [7:0]    data,
    input  logic [PW-1:0] period,
    output logic          txd,
    output logic          busy
);
    import abb_pkg::*;

    localparam int BIT_W = $clog2(FRAME_BITS);

    typedef struct packed {
        logic                  busy;
        logic                  txd;
        logic [PW-1:0]         cnt;
        logic [BIT_W-1:0]      idx;
        logic [FRAME_BITS-1:0] sh;
    } tx_t;

    tx_t tx_d, tx_q;

    always_comb begin
        tx_d = tx_q;
        if (!tx_q.busy) begin
            tx_d.txd = 1'b1;
            if (start) begin
                tx_d.busy = 1'b1;
                tx_d.sh   = {1'b1, data, 1'b0};
                tx_d.txd  = 1'b0;
                tx_d.cnt  = PW'(1);
                tx_d.idx  = '0;
            end
        end else if (tx_q.cnt >= period) begin
            tx_d.cnt = PW'(1);
            if (tx_q.idx == BIT_W'(FRAME_BITS - 1)) begin
                tx_d.busy = 1'b0;
                tx_d.txd  = 1'b1;
            end else begin
                tx_d.idx = tx_q.idx + 1'b1;
                tx_d.sh  = {1'b1, tx_q.sh[FRAME_BITS-1:1]};
                tx_d.txd = tx_q.sh[1];
            end
        end else begin
            tx_d.cnt = tx_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_q     <= '0;
            tx_q.txd <= 1'b1;
        end else begin
            tx_q <= tx_d;
        end
    end

    assign txd  = tx_q.txd;
    assign busy = tx_q.busy;
endmodule

// File: rtl/abb_uart_rx.sv
module abb_uart_rx #(
    parameter int PW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          line,
    input  logic [PW-1:0] period,
    output logic          valid,
    output logic [7:0]    data,
    output logic          ferr
);
    import abb_pkg::*;

    localparam int IDX_W = $clog2(DATA_BITS);

    typedef struct packed {
        rx_state_e      st;
        logic [PW-1:0]  cnt;
        logic [IDX_W-1:0] idx;
        logic [7:0]     sh;
        logic           valid;
        logic [7:0]     data;
        logic           ferr;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [PW-1:0] half;

    always_comb begin
        half       = period >> 1;
        rx_d       = rx_q;
        rx_d.valid = 1'b0;
        case (rx_q.st)
            RX_ARM: begin
                if (line) rx_d.st = RX_IDLE;
            end
            RX_IDLE: begin
                if (!line) begin
                    rx_d.st  = RX_START;
                    rx_d.cnt = PW'(1);
                end
            end
            RX_START: begin
                if (rx_q.cnt >= half) begin
                    rx_d.cnt = PW'(1);
                    rx_d.idx = '0;
                    rx_d.st  = line ? RX_ARM : RX_DATA;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            RX_DATA: begin
                if (rx_q.cnt >= period) begin
                    rx_d.cnt = PW'(1);
                    rx_d.sh  = {line, rx_q.sh[7:1]};
                    if (rx_q.idx == IDX_W'(DATA_BITS - 1)) rx_d.st  = RX_STOP;
                    else                                   rx_d.idx = rx_q.idx + 1'b1;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            RX_STOP: begin
                if (rx_q.cnt >= period) begin
                    rx_d.valid = 1'b1;
                    rx_d.data  = rx_q.sh;
                    rx_d.ferr  = !line;
                    rx_d.st    = RX_ARM;
                end else begin
                    rx_d.cnt = rx_q.cnt + 1'b1;
                end
            end
            default: rx_d.st = RX_ARM;
        endcase
        if (!en) begin
            rx_d.st    = RX_ARM;
            rx_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rx_q <= '0;
        else        rx_q <= rx_d;
    end

    assign valid = rx_q.valid;
    assign data  = rx_q.data;
    assign ferr  = rx_q.ferr;
endmodule

// File: rtl/autobaud_boot.sv
module autobaud_boot #(
    parameter int CNT_W    = 18,
    parameter int PERIOD_W = 16,
    parameter int MIN_LOW  = 36,
    parameter int MIN_IDLE = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                rxd,
    output logic                txd,
    output logic [PERIOD_W-1:0] bit_period,
    output logic                lock,
    output logic                done,
    output logic                error
);
    import abb_pkg::*;

    localparam int DIV_W = CNT_W + 1;

    typedef struct packed {
        hs_state_e           st;
        logic [PERIOD_W-1:0] period;
        logic                lock;
        logic                tx_go;
    } hs_t;

    hs_t hs_d, hs_q;

    logic             rx_s;
    logic             meas_valid, meas_ok;
    logic [CNT_W-1:0] meas_cnt;
    logic             div_start, div_done;
    logic [DIV_W-1:0] div_in, div_quot;
    logic [PERIOD_W-1:0] period_fit;
    logic             tx_busy;
    logic             rx_valid, rx_ferr;
    logic [7:0]       rx_data;

    abb_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    abb_low_timer #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW), .MIN_IDLE(MIN_IDLE)) timer_i (
        .clk(clk), .rst_n(rst_n), .en(hs_q.st == HS_MEASURE), .line(rx_s),
        .meas_valid(meas_valid), .meas_ok(meas_ok), .meas_cnt(meas_cnt)
    );

    assign div_in    = {1'b0, meas_cnt} + DIV_W'(ROUND_ADD);
    assign div_start = (hs_q.st == HS_MEASURE) && meas_valid && meas_ok;

    abb_div_const #(.IN_W(DIV_W), .DIVISOR(LOW_BITS)) div_i (
        .clk(clk), .rst_n(rst_n), .start(div_start), .dividend(div_in),
        .done(div_done), .quot(div_quot)
    );

    generate
        if (DIV_W > PERIOD_W) begin : g_clip
            assign period_fit = (|div_quot[DIV_W-1:PERIOD_W]) ? '1 : div_quot[PERIOD_W-1:0];
        end else begin : g_pad
            assign period_fit = PERIOD_W'(div_quot);
        end
    endgenerate

    abb_uart_tx #(.PW(PERIOD_W)) tx_i (
        .clk(clk), .rst_n(rst_n), .start(hs_q.tx_go), .data(ADJ_END_BYTE),
        .period(hs_q.period), .txd(txd), .busy(tx_busy)
    );

    abb_uart_rx #(.PW(PERIOD_W)) rx_i (
        .clk(clk), .rst_n(rst_n), .en(hs_q.st == HS_CONFIRM), .line(rx_s),
        .period(hs_q.period), .valid(rx_valid), .data(rx_data), .ferr(rx_ferr)
    );

    always_comb begin
        hs_d       = hs_q;
        hs_d.lock  = 1'b0;
        hs_d.tx_go = 1'b0;
        case (hs_q.st)
            HS_MEASURE: if (div_start) hs_d.st = HS_DIVIDE;
            HS_DIVIDE: begin
                if (div_done) begin
                    hs_d.period = period_fit;
                    hs_d.lock   = 1'b1;
                    hs_d.tx_go  = 1'b1;
                    hs_d.st     = HS_SEND;
                end
            end
            HS_SEND: if (!tx_busy && !hs_q.tx_go) hs_d.st = HS_CONFIRM;
            HS_CONFIRM: begin
                if (rx_valid) begin
                    if (!rx_ferr && (rx_data == CONFIRM_BYTE)) hs_d.st = HS_DONE;
                    else                                       hs_d.st = HS_FAIL;
                end
            end
            HS_DONE, HS_FAIL: hs_d.st = hs_q.st;
            default: hs_d.st = HS_MEASURE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hs_q <= '0;
        else        hs_q <= hs_d;
    end

    assign bit_period = hs_q.period;
    assign lock       = hs_q.lock;
    assign done       = (hs_q.st == HS_DONE);
    assign error      = (hs_q.st == HS_FAIL);
endmodule

// File: rtl/abb_boot_checker.sv
module abb_boot_checker #(
    parameter int PERIOD_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                txd,
    input logic [PERIOD_W-1:0] bit_period,
    input logic                lock,
    input logic                done,
    input logic                error
);
    logic        seen_q;
    logic [31:0] low_run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seen_q    <= 1'b0;
            low_run_q <= '0;
        end else begin
            seen_q    <= seen_q | lock;
            low_run_q <= txd ? 32'd0 : low_run_q + 32'd1;
        end
    end

    p_lock_nonzero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lock |-> (bit_period != '0));
    p_lock_once_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> !lock);
    p_period_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seen_q |-> $stable(bit_period));
    p_tx_low_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
        low_run_q <= 32'd9 * 32'(bit_period));
    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);
    p_done_after_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> seen_q);
    p_error_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        error |=> error);
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error));
    p_tx_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !seen_q |-> txd);
endmodule

bind autobaud_boot abb_boot_checker #(.PERIOD_W(PERIOD_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .txd(txd), .bit_period(bit_period),
    .lock(lock), .done(done), .error(error)
);

// File: tb/autobaud_boot_tb.sv
`timescale 1ns/1ps
module autobaud_boot_tb_top;
    localparam int CNT_W    = 12;
    localparam int PERIOD_W = 16;
    localparam int MIN_LOW  = 36;
    localparam int MIN_IDLE = 8;
    localparam int SAT      = (1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic rxd = 1'b1;
    logic txd, lock, done, error;
    logic [PERIOD_W-1:0] bit_period;

    int n_total = 0;
    int n_fail  = 0;
    int cycles  = 0;

    always #2 clk = ~clk;

    autobaud_boot #(.CNT_W(CNT_W), .PERIOD_W(PERIOD_W), .MIN_LOW(MIN_LOW), .MIN_IDLE(MIN_IDLE)) dut_i (
        .clk(clk), .rst_n(rst_n), .rxd(rxd), .txd(txd),
        .bit_period(bit_period), .lock(lock), .done(done), .error(error)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            n_total = n_total + 1;
            n_fail  = n_fail + 1;
            $display("FAIL watchdog: actual %0d cycles expected < 190000", cycles);
            $display("%0d/%0d checks passed", n_total - n_fail, n_total);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_total = n_total + 1;
        if (!ok) begin
            n_fail = n_fail + 1;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic v, input int n);
        rxd = v;
        repeat (n) @(negedge clk);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        rxd   = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wait_lock(input int n, output bit got);
        got = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (lock) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic send_frame(input logic [7:0] b, input int p, input logic stop_lvl);
        hold(1'b0, p);
        for (int i = 0; i < 8; i++) hold(b[i], p);
        hold(stop_lvl, p);
        rxd = 1'b1;
    endtask

    // reset, idle, one low pulse of length len; returns whether lock came
    task automatic measure(input int len, output bit got);
        do_reset();
        hold(1'b1, 20);
        hold(1'b0, len);
        rxd = 1'b1;
        wait_lock(80, got);
    endtask

    // watch the completion frame on txd (R6, R10)
    task automatic watch_tx(input int p);
        int lo;
        int hi;
        lo = 0;
        hi = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (!txd) break;
        end
        while (!txd && lo < 9 * p + 50) begin
            lo++;
            @(negedge clk);
        end
        check(lo == 9 * p, "R6 completion frame low length", lo, 9 * p);
        for (int i = 0; i < p + 2; i++) begin
            if (txd) hi++;
            @(negedge clk);
        end
        check(hi == p + 2, "R10 txd high after stop", hi, p + 2);
    endtask

    initial begin
        bit got;
        int exp_p;

        // R1 reset state
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        check(txd && !lock && !done && !error && bit_period == 0, "R1 during reset",
              {txd, lock, done, error}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        check(txd && !lock && !done && !error && bit_period == 0, "R1 after release",
              int'(bit_period), 0);

        // R2 R6 R7 sweep over low lengths
        for (int len = MIN_LOW; len <= 150; len++) begin
            exp_p = (len + 4) / 9;
            measure(len, got);
            check(got && int'(bit_period) == exp_p, "R2 rounded bit period",
                  got ? int'(bit_period) : -1, exp_p);
            if (got) begin
                watch_tx(exp_p);
                hold(1'b1, 4);
                send_frame(8'h55, exp_p, 1'b1);
                hold(1'b1, 6);
                check(done && !error, "R7 confirmation accepted", {done, error}, 2'b10);
            end
        end

        // R3 too short, then a good one
        measure(MIN_LOW - 1, got);
        check(!got, "R3 short pulse discarded", got, 0);
        hold(1'b1, 20);
        hold(1'b0, 90);
        rxd = 1'b1;
        wait_lock(80, got);
        check(got && bit_period == 10, "R3 next pulse measured", int'(bit_period), 10);

        // R3 saturation boundary
        measure(SAT, got);
        check(!got, "R3 saturated pulse discarded", got, 0);
        measure(SAT - 1, got);
        check(got && int'(bit_period) == (SAT - 1 + 4) / 9, "R3 longest accepted pulse",
              int'(bit_period), (SAT - 1 + 4) / 9);

        // R4 falling edge without enough idle
        do_reset();
        hold(1'b1, 20);
        hold(1'b0, 20);
        hold(1'b1, MIN_IDLE - 5);
        hold(1'b0, 90);
        rxd = 1'b1;
        wait_lock(60, got);
        check(!got, "R4 unarmed edge ignored", got, 0);
        hold(1'b0, 63);
        rxd = 1'b1;
        wait_lock(80, got);
        check(got && bit_period == 7, "R4 armed edge measured", int'(bit_period), 7);

        // R8 wrong byte
        measure(90, got);
        watch_tx(10);
        hold(1'b1, 4);
        send_frame(8'h54, 10, 1'b1);
        hold(1'b1, 6);
        check(error && !done, "R8 wrong byte flags error", {done, error}, 2'b01);
        hold(1'b1, 100);
        check(error && !done, "R8 error held", {done, error}, 2'b01);

        // R8 framing error, R9 restart at a different rate
        measure(117, got);
        check(got && bit_period == 13, "R9 restart after error", int'(bit_period), 13);
        watch_tx(13);
        hold(1'b1, 4);
        send_frame(8'h55, 13, 1'b0);
        hold(1'b1, 6);
        check(error && !done, "R8 low stop bit flags error", {done, error}, 2'b01);

        do_reset();
        check(!error && !done && bit_period == 0 && txd, "R9 reset clears", int'(bit_period), 0);

        $display("%0d/%0d checks passed", n_total - n_fail, n_total);
        $finish;
    end
endmodule